// File: doc/BRIEF.md
# Indexed Byte Configuration Port

This block gives a host an indirect window onto a bank of 256 byte-wide configuration registers through only two consecutive I/O byte addresses. The host first writes a register number to the lower address, which latches it as the current index. Accesses to the upper address then reach the register that index names. A read at either address returns the selected register one cycle after the request.

Writes to the data address pass through a per-index filter. Most of the bank is read-only. A group of registers near the top accepts any value. Two registers are keyed: each takes a write only when the data equals one fixed value. The whole port answers only while the `portEn` input is high. That input is meant to follow one bit of a configuration byte held elsewhere in the chip. While the port is disabled, reads return 0xFF without a hit, and writes change neither the index nor the bank.

Top module: `cfg_index_port`

## Requirements
- R1: A write at `BASE_ADDR` (default 0x3F0) loads `wdata` into the index. The index keeps its value until the next such write.
- R2: A read at `BASE_ADDR` or `BASE_ADDR+1` returns the register selected by the index on `rdata`, with `rdHit` high, in the cycle after `rdEn`.
- R3: A write at `BASE_ADDR+1` is discarded when the index is 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF.
- R4: A write at `BASE_ADDR+1` stores any value when the index is 0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 or 0xFC.
- R5: Register 0xE7 accepts a write only when the data is 0xFE, and register 0xE8 only when the data is 0xBE. Any other value leaves the register unchanged.
- R6: After reset the index is 0x00 and the registers are 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE, 0xE8=0xBE. Every other register is 0x00.
- R7: While `portEn` is low, a read returns 0xFF with `rdHit` low, and writes change neither the index nor any register.
- R8: Accesses at any address other than the two port addresses are ignored. A read there returns 0xFF with `rdHit` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| portEn | input | 1 | Port visible while high |
| addr | input | ADDR_W | Byte address of the access |
| wrEn | input | 1 | Write strobe, one cycle per byte |
| rdEn | input | 1 | Read strobe, one cycle per byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rdEn; 0xFF when no hit |
| rdHit | output | 1 | High in the cycle rdata carries an accepted read |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a base of 0x3F0 and the full 8-bit index. With these values every one of the 256 registers can be reached. The bench reads all of them after reset, then writes two different patterns to each and reads each back through the data address. This exercises every filter class, including the rejected values at the two keyed registers. Further sequences cover reads at the index address, accesses at neighbouring addresses and traffic while the port is disabled, and they compare results against a model built from the index rules.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  typedef struct packed {
    logic idxLoad;
    logic dataWr;
    logic rdAccept;
  } cfgp_strb_t;

  typedef enum logic [1:0] {
    WR_LOCKED = 2'd0,
    WR_OPEN   = 2'd1,
    WR_KEYED  = 2'd2
  } wr_class_e;

  function automatic wr_class_e classOf(input logic [7:0] idx);
    wr_class_e c;
    c = WR_LOCKED;
    if (idx >= 8'hE0) begin
      case (idx)
        8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE6,
        8'hEE, 8'hEF, 8'hF0, 8'hF1, 8'hF2,
        8'hF4, 8'hF6, 8'hF8, 8'hFC: c = WR_OPEN;
        8'hE7, 8'hE8:               c = WR_KEYED;
        default:                    c = WR_LOCKED;
      endcase
    end
    return c;
  endfunction

  function automatic logic [7:0] keyOf(input logic [7:0] idx);
    return (idx == 8'hE7) ? 8'hFE : 8'hBE;
  endfunction

  function automatic logic [7:0] resetValueOf(input logic [7:0] idx);
    logic [7:0] v;
    case (idx)
      8'hE0:   v = 8'h3C;
      8'hE2:   v = 8'h03;
      8'hE3:   v = 8'hFC;
      8'hE6:   v = 8'hDE;
      8'hE7:   v = 8'hFE;
      8'hE8:   v = 8'hBE;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/cfgp_ctrl.sv
module cfgp_ctrl
  import cfgp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output cfgp_strb_t        strb
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

  logic hitIdx, hitDat;

  always_comb begin
    hitIdx        = (addr == BASE_ADDR);
    hitDat        = (addr == DATA_ADDR);
    strb.idxLoad  = portEn && wrEn && hitIdx;
    strb.dataWr   = portEn && wrEn && hitDat;
    strb.rdAccept = portEn && rdEn && (hitIdx || hitDat);
  end

  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !portEn |-> (strb == '0));

  // R8
  foreign_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr != BASE_ADDR && addr != DATA_ADDR) |-> (strb == '0));

endmodule

// File: rtl/cfgp_wr_filter.sv
module cfgp_wr_filter
  import cfgp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dataWr,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output logic       wrAccept
);
  wr_class_e cls;

  always_comb begin
    cls = classOf(idx);
    unique case (cls)
      WR_OPEN:  wrAccept = dataWr;
      WR_KEYED: wrAccept = dataWr && (wdata == keyOf(idx));
      default:  wrAccept = 1'b0;
    endcase
  end

  // R5
  keyed_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrAccept && (idx == 8'hE7 || idx == 8'hE8)) |->
      (wdata == ((idx == 8'hE7) ? 8'hFE : 8'hBE)));

  // R3
  locked_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idx < 8'hE0) |-> !wrAccept);

endmodule

// File: rtl/cfgp_datapath.sv
module cfgp_datapath
  import cfgp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  cfgp_strb_t strb,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rdHit
);
  localparam int NUM_REGS = 1 << IDX_W;

  logic [IDX_W-1:0] idxQ;
  logic [7:0]       regQ [NUM_REGS];
  logic             wrAccept;
  logic [NUM_REGS-1:0] entryWe;
  logic [7:0]       selByte;

  cfgp_wr_filter u_filter (
    .clk      (clk),
    .rstN     (rstN),
    .dataWr   (strb.dataWr),
    .idx      (8'(idxQ)),
    .wdata    (wdata),
    .wrAccept (wrAccept)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_we
    assign entryWe[g] = wrAccept && (idxQ == IDX_W'(g));
  end

  assign selByte = regQ[idxQ];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
    end else if (strb.idxLoad) begin
      idxQ <= IDX_W'(wdata);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (!rstN) begin
        regQ[i] <= resetValueOf(8'(i));
      end else if (entryWe[i]) begin
        regQ[i] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata <= 8'hFF;
      rdHit <= 1'b0;
    end else begin
      rdata <= strb.rdAccept ? selByte : 8'hFF;
      rdHit <= strb.rdAccept;
    end
  end

  // R1
  index_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.idxLoad |=> $stable(idxQ));

  // R3
  rejected_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataWr && !wrAccept) |=> $stable(selByte));

  // R2
  read_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdAccept |=> rdHit);

  // R7
  idle_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdAccept |=> (rdata == 8'hFF && !rdHit));

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfgp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rdHit
);
  cfgp_strb_t strb;

  cfgp_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .portEn (portEn),
    .addr   (addr),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .strb   (strb)
  );

  cfgp_datapath #(.IDX_W(IDX_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .wdata (wdata),
    .rdata (rdata),
    .rdHit (rdHit)
  );

endmodule

// File: tb/cfg_index_port_bench.sv
`timescale 1ns/1ps
module cfg_index_port_bench;
  localparam logic [15:0] IDX_A = 16'h03F0;
  localparam logic [15:0] DAT_A = 16'h03F1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic portEn = 1'b0;
  logic [15:0] addr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rdHit;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] model [256];

  always #4 clk = ~clk;

  cfg_index_port u_cfg_index_port (
    .clk(clk), .rstN(rstN), .portEn(portEn), .addr(addr),
    .wrEn(wrEn), .rdEn(rdEn), .wdata(wdata), .rdata(rdata), .rdHit(rdHit)
  );

  // 0 locked, 1 open, 2 keyed -- from R3/R4/R5
  function automatic int kind(input int i);
    if (i < 'hE0) return 0;
    if (i <= 'hE3 || i == 'hE6 || (i >= 'hEE && i <= 'hF2) ||
        i == 'hF4 || i == 'hF6 || i == 'hF8 || i == 'hFC) return 1;
    if (i == 'hE7 || i == 'hE8) return 2;
    return 0;
  endfunction

  function automatic void modelWrite(input int i, input logic [7:0] d);
    if (kind(i) == 1) model[i] = d;
    else if (kind(i) == 2 && d == ((i == 'hE7) ? 8'hFE : 8'hBE)) model[i] = d;
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [8:0] r);
    @(negedge clk); addr = a; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0; r = {rdHit, rdata};
  endtask

  initial begin
    #(8 * 190000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [8:0] r;
    for (int i = 0; i < 256; i++) begin
      case (i)
        'hE0: model[i] = 8'h3C; 'hE2: model[i] = 8'h03; 'hE3: model[i] = 8'hFC;
        'hE6: model[i] = 8'hDE; 'hE7: model[i] = 8'hFE; 'hE8: model[i] = 8'hBE;
        default: model[i] = 8'h00;
      endcase
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1; portEn = 1'b1;
    check("R6 rdata idle", {rdHit, rdata}, 9'h0FF);
    // R6: index is 0 after reset
    busRead(DAT_A, r); check("R6 index0", r, {1'b1, model[0]});
    // R6 sweep of reset values
    for (int i = 0; i < 256; i++) begin
      busWrite(IDX_A, 8'(i));
      busRead(DAT_A, r); check("R6 reset value", r, {1'b1, model[i]});
    end
    // R3 R4 R5 sweeps with two patterns
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 256; i++) begin
        logic [7:0] d;
        d = (p == 0) ? (8'(i) ^ 8'hA5) : ~8'(i);
        busWrite(IDX_A, 8'(i));
        busWrite(DAT_A, d);
        modelWrite(i, d);
        busRead(DAT_A, r);
        check(kind(i) == 0 ? "R3 locked" : (kind(i) == 1 ? "R4 open" : "R5 keyed"),
              r, {1'b1, model[i]});
      end
    end
    // R5 matching and mismatching key values
    busWrite(IDX_A, 8'hE7); busWrite(DAT_A, 8'h00); modelWrite('hE7, 8'h00);
    busRead(DAT_A, r); check("R5 E7 reject", r, {1'b1, model['hE7]});
    busWrite(DAT_A, 8'hFE); modelWrite('hE7, 8'hFE);
    busRead(DAT_A, r); check("R5 E7 accept", r, 9'h1FE);
    busWrite(IDX_A, 8'hE8); busWrite(DAT_A, 8'hFE); modelWrite('hE8, 8'hFE);
    busRead(DAT_A, r); check("R5 E8 reject", r, 9'h1BE);
    // R2: read at index address returns selected register
    busWrite(IDX_A, 8'hE1); busWrite(DAT_A, 8'h77); modelWrite('hE1, 8'h77);
    busRead(IDX_A, r); check("R2 read at index addr", r, 9'h177);
    busRead(DAT_A, r); check("R2 read at data addr", r, 9'h177);
    // R8: neighbouring addresses ignored
    busWrite(16'h03F2, 8'h11); busWrite(16'h03EF, 8'hE0);
    busRead(DAT_A, r); check("R8 no effect", r, 9'h177);
    busRead(16'h03F2, r); check("R8 foreign read", r, 9'h0FF);
    busRead(16'h13F0, r); check("R8 alias read", r, 9'h0FF);
    // R7: disabled port
    portEn = 1'b0;
    busWrite(IDX_A, 8'hE0); busWrite(DAT_A, 8'h22);
    busRead(DAT_A, r); check("R7 disabled read", r, 9'h0FF);
    busRead(IDX_A, r); check("R7 disabled read idx", r, 9'h0FF);
    portEn = 1'b1;
    busRead(DAT_A, r); check("R7 index untouched", r, 9'h177);
    busWrite(IDX_A, 8'hE0);
    busRead(DAT_A, r); check("R7 register untouched", r, {1'b1, model['hE0]});
    // R1: index holds across data writes and reads
    busWrite(IDX_A, 8'hF4); busWrite(DAT_A, 8'h5C); busWrite(DAT_A, 8'h6D);
    busRead(DAT_A, r); check("R1 index held", r, 9'h16D);
    busRead(IDX_A, r); check("R1 index held 2", r, 9'h16D);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule